// File: doc/BRIEF.md
# Zero-Initialising Single-Port RAM Wrapper

This block wraps an inferred synchronous RAM. After every synchronous reset it visits every location in turn and writes zero to it. Only after that does it give the memory to the user. A two-state sequencer drives a select line for a multiplexer on the write port:

- **ST_CLEAR**: an internal address counter drives the write port. The write enable is forced on and the data is all zeros.
- **ST_RUN**: the user's write and read requests reach the array unchanged.

There are two transitions. **T_DONE** goes from ST_CLEAR to ST_RUN on the edge that writes the highest address. **T_RESTART** goes from any state to ST_CLEAR, with the counter at 0, on any edge where reset is high.

The `ready` output tells the surrounding logic when the contents are defined and user writes take effect. The depth and word width are parameters. The address width is derived from the depth.

Top module: `zero_init_ram`

## Requirements
- R1: While `rst` is high, and on the edge that samples it high, `ready` is driven low. After `rst` falls, `ready` first reads high after exactly DEPTH rising edges.
- R2: When `ready` first rises, every address in 0..DEPTH-1 reads back as zero.
- R3: A user write (`wr_en` = 1) presented while `ready` is low changes no memory location. This includes a write on the final clearing edge.
- R4: In ST_RUN, a write stores `wr_data` at `wr_addr` on the clock edge. A later read of that address returns it.
- R5: Asserting `rst` while `ready` is high drops `ready` and restarts the clear from address 0. Afterwards all locations read zero again.
- R6: Once high, `ready` stays high for as long as `rst` stays low, whatever the user inputs do.
- R7: `rd_data` is registered. It takes the word at `rd_addr` on a rising edge and holds it between edges. When the read and the write on the same edge use the same address, `rd_data` returns the old word (read-first).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; starts the clear |
| wr_en | input | 1 | User write enable, honoured only while ready |
| wr_addr | input | AW | User write address |
| wr_data | input | WIDTH | User write data |
| rd_addr | input | AW | User read address |
| rd_data | output | WIDTH | Registered read data |
| ready | output | 1 | High once the clear has finished |

## Verification
The bench counts edges from reset release to the rise of `ready`. A sequencer that stops one address early or one address late would move that count away from DEPTH.

It issues user writes to address 0 in the middle of the clear and on its final edge. A mux that hands over the port too early would leave that data in memory.

A table of write and read vectors probes the read-first behaviour and the one-cycle read latency. A design with a combinational or write-first read would return the new word on that edge.

A reset in the middle of operation, with data already stored, must clear the array again. A sequencer that resumes from its old counter value would leave stale words behind.

// File: rtl/zinit_pkg.sv
package zinit_pkg;
    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_RUN   = 1'b1
    } zi_state_e;
endpackage

// File: rtl/zinit_seq.sv
module zinit_seq
    import zinit_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    output logic          clr_sel,
    output logic [AW-1:0] clr_addr,
    output logic          ready
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    zi_state_e     state_q, state_d;
    logic [AW-1:0] cnt_q;
    logic          at_last;

    assign at_last = (cnt_q == LAST_ADDR);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_CLEAR;   // T_RESTART
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (at_last) state_d = ST_RUN;  // T_DONE
            ST_RUN:   state_d = ST_RUN;
        endcase
    end

    // clear address counter
    always_ff @(posedge clk) begin
        if (rst)                    cnt_q <= '0;
        else if (state_q == ST_CLEAR) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end

    // outputs
    always_comb begin
        clr_sel  = 1'b0;
        ready    = 1'b0;
        unique case (state_q)
            ST_CLEAR: clr_sel = 1'b1;
            ST_RUN:   ready   = 1'b1;
        endcase
        clr_addr = cnt_q;
    end
endmodule

// File: rtl/zinit_wmux.sv
module zinit_wmux #(
    parameter int AW    = 4,
    parameter int WIDTH = 8
) (
    input  logic             clr_sel,
    input  logic [AW-1:0]    clr_addr,
    input  logic             usr_we,
    input  logic [AW-1:0]    usr_addr,
    input  logic [WIDTH-1:0] usr_data,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [WIDTH-1:0] mem_data
);
    always_comb begin
        if (clr_sel) begin
            mem_we   = 1'b1;
            mem_addr = clr_addr;
            mem_data = '0;
        end else begin
            mem_we   = usr_we;
            mem_addr = usr_addr;
            mem_data = usr_data;
        end
    end
endmodule

// File: rtl/zinit_sram.sv
module zinit_sram #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        rdata <= store[raddr];
    end
endmodule

// File: rtl/zero_init_ram.sv
module zero_init_ram #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data,
    output logic             ready
);
    logic             clr_sel;
    logic [AW-1:0]    clr_addr;
    logic             mem_we;
    logic [AW-1:0]    mem_addr;
    logic [WIDTH-1:0] mem_data;

    zinit_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
        .clk(clk), .rst(rst),
        .clr_sel(clr_sel), .clr_addr(clr_addr), .ready(ready)
    );

    zinit_wmux #(.AW(AW), .WIDTH(WIDTH)) u_wmux (
        .clr_sel(clr_sel), .clr_addr(clr_addr),
        .usr_we(wr_en), .usr_addr(wr_addr), .usr_data(wr_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    zinit_sram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_sram (
        .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_data),
        .raddr(rd_addr), .rdata(rd_data)
    );
endmodule

// File: rtl/zinit_chk.sv
module zinit_chk #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [AW-1:0]    wr_addr,
    input logic [WIDTH-1:0] wr_data,
    input logic [AW-1:0]    rd_addr,
    input logic [WIDTH-1:0] rd_data,
    input logic             ready
);
    localparam int CW = $clog2(DEPTH + 2) + 1;
    logic [CW-1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                              since_rst <= '0;
        else if (!ready && since_rst < CW'(DEPTH + 1)) since_rst <= since_rst + 1'b1;
    end

    // R1
    ready_reset_chk: assert property (@(posedge clk) rst |=> !ready);

    // R1
    ready_latency_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> since_rst == CW'(DEPTH));

    // R6
    ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    // R4
    write_read_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && wr_en) ##1 (rd_addr == $past(wr_addr) && !(wr_en && wr_addr == rd_addr))
        |=> rd_data == $past(wr_data, 2));
endmodule

bind zero_init_ram zinit_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_zinit_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready)
);

// File: tb/test_zero_init_ram.sv
module test_zero_init_ram;
    localparam int DEPTH = 16;
    localparam int WIDTH = 8;
    localparam int AW    = $clog2(DEPTH);
    localparam int NV    = 9;

    // vector: {we, waddr[3:0], wdata[7:0], raddr[3:0], expected rd_data[7:0]}
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 4'd3,  8'hA5, 4'd3,  8'h00},
        {1'b1, 4'd7,  8'h3C, 4'd3,  8'hA5},
        {1'b0, 4'd7,  8'hFF, 4'd7,  8'h3C},
        {1'b1, 4'd15, 8'h81, 4'd0,  8'h00},
        {1'b1, 4'd3,  8'h5A, 4'd15, 8'h81},
        {1'b0, 4'd0,  8'h00, 4'd3,  8'h5A},
        {1'b1, 4'd0,  8'hFF, 4'd0,  8'h00},
        {1'b0, 4'd0,  8'h00, 4'd0,  8'hFF},
        {1'b0, 4'd0,  8'h00, 4'd9,  8'h00}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [AW-1:0]    wr_addr = '0;
    logic [WIDTH-1:0] wr_data = '0;
    logic [AW-1:0]    rd_addr = '0;
    logic [WIDTH-1:0] rd_data;
    logic             ready;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    zero_init_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_zero_init_ram (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic read_at(input int a, input int exp, input string req);
        @(negedge clk);
        wr_en   = 1'b0;
        rd_addr = AW'(a);
        tick();
        check(req, int'(rd_data), exp);
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    initial begin
        int rise_at;
        // reset state, R1
        repeat (3) tick();
        check("R1 ready low in reset", int'(ready), 0);

        // release and count edges; R3 writes during clear
        @(negedge clk);
        rst = 1'b0;
        rise_at = -1;
        for (int k = 1; k <= DEPTH + 2; k++) begin
            if (k == 5 || k == DEPTH) begin
                wr_en = 1'b1; wr_addr = '0; wr_data = 8'hEE;
            end else begin
                wr_en = 1'b0;
            end
            tick();
            if (ready && rise_at < 0) rise_at = k;
            @(negedge clk);
        end
        wr_en = 1'b0;
        check("R1 ready latency", rise_at, DEPTH);

        // R2, R3: all zero after clear
        for (int a = 0; a < DEPTH; a++) read_at(a, 0, (a == 0) ? "R3 write during clear ignored" : "R2 zero after clear");

        // vector table, R4 / R7
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            wr_en   = VEC[v][24];
            wr_addr = VEC[v][23:20];
            wr_data = VEC[v][19:12];
            rd_addr = VEC[v][11:8];
            tick();
            check("R4 R7 vector", int'(rd_data), int'(VEC[v][7:0]));
        end
        @(negedge clk);
        wr_en = 1'b0;

        // R7: output holds between edges
        rd_addr = 4'd7;
        #2;
        check("R7 rd_data held between edges", int'(rd_data), 8'h00);
        tick();
        check("R7 new read after edge", int'(rd_data), 8'h3C);

        // R6
        check("R6 ready held", int'(ready), 1);

        // R5: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        tick();
        check("R5 ready drops on reset", int'(ready), 0);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 1; k <= DEPTH; k++) begin
            tick();
            if (k == DEPTH - 1) check("R5 still clearing", int'(ready), 0);
        end
        check("R5 ready after re-clear", int'(ready), 1);
        read_at(3, 0, "R5 cleared addr 3");
        read_at(7, 0, "R5 cleared addr 7");
        read_at(15, 0, "R5 cleared addr 15");
        read_at(0, 0, "R5 cleared addr 0");

        done = 1'b1;
        finish_up();
    end
endmodule